// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block owns the 8-bit stack pointer of a small byte-oriented processor core and runs the short multi-cycle memory sequences that use the stack. These are push and pull of the accumulator and of the status byte, subroutine call and return, return from interrupt, software break, and the two transfers between the stack pointer and the X index. The core decodes an instruction and hands the sequencer one command with everything the command needs: opcode class, address of the instruction, 16-bit operand, accumulator, status and X. The sequencer then drives a byte-wide memory port. When the command finishes it presents the new program counter, status, accumulator or X. Each of these comes with its own write strobe.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on the rising edge where `cmd_valid` and `cmd_ready` are both high, and its fields are latched on that edge. `cmd_ready` then stays low until the command completes, so the core holds `cmd_valid` as long as it has to wait. The result strobes are plain control pins and are valid only in the single cycle where `done` is high. Stack bytes live at address `{STACK_PAGE, sp}`. The break target is read from two bytes starting at `VEC_ADDR`, low byte first.

Top module: `stack_seq`

## Requirements
- R1: While reset is held and right after it, `sp_out` is SP_INIT (0xFF), `cmd_ready` is 1, and `done`, `mem_we` and `mem_re` are 0.
- R2: Count the accept cycle as cycle 1. `done` is high in cycle N and `cmd_ready` is low in cycles 2..N, then high again in cycle N+1. N is 3 for a push, 4 for a pull, 6 for call, return and return-from-interrupt, 7 for break, and 2 for every other code.
- R3: A push writes the byte to `{0x01, sp}` and the pointer then goes down by one. It wraps from 0x00 to 0xFF.
- R4: A pull first raises the pointer by one and then reads `{0x01, sp}` at the new value. It wraps from 0xFF to 0x00.
- R5: Pulling the accumulator (code 2) returns the byte on `acc_new`. It also gives `sr_new` equal to `cmd_status` with bit 7 (N) set to the byte's bit 7 and bit 1 (Z) set when the byte is zero. Pushes (code 0 accumulator, code 1 status) write the value unchanged and raise no result strobe.
- R6: Pulling status (code 3) returns the whole pulled byte on `sr_new`.
- R7: Call (code 4) pushes `cmd_pc`+2, the address of its last operand byte, high byte first, and loads `pc_new` with `cmd_operand`.
- R8: Return (code 5) pulls the low byte and then the high byte, and loads `pc_new` with that address plus one, modulo 2^16.
- R9: Return from interrupt (code 6) pulls status first and then the low and high address bytes. It loads `sr_new` and `pc_new` with no increment.
- R10: Break (code 7) pushes `cmd_pc`+2 (high byte, then low byte), then `cmd_status` with bit 4 set. It then reads `VEC_ADDR` and `VEC_ADDR`+1 into `pc_new` (low byte, high byte) and gives `sr_new` = `cmd_status` with bit 2 set.
- R11: Stack-to-X (code 8) gives `x_new` = `sp`, with N and Z of `sr_new` taken from that value.
- R12: X-to-stack (code 9) loads the pointer from `cmd_x` and raises no status strobe. The new pointer is on `sp_out` in cycle N+1.
- R13: `mem_we` and `mem_re` are never high together. Every write is inside the stack page. Read data is taken from `mem_rdata` one cycle after `mem_re`. Per command the bus carries one access for a push or a pull, two for a call, and five for a break.
- R14: Codes 10 to 15 complete with no memory access, no result strobe and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 4 | Command code (0..9, see requirements) |
| cmd_pc | input | 16 | Address of the instruction's opcode byte |
| cmd_operand | input | 16 | Call target |
| cmd_acc | input | 8 | Accumulator value |
| cmd_status | input | 8 | Status byte (N=7, V=6, B=4, D=3, I=2, Z=1, C=0) |
| cmd_x | input | 8 | X index value |
| done | output | 1 | Command completes this cycle |
| pc_we | output | 1 | Load program counter |
| pc_new | output | 16 | New program counter |
| sr_we | output | 1 | Load status |
| sr_new | output | 8 | New status |
| acc_we | output | 1 | Load accumulator |
| acc_new | output | 8 | New accumulator |
| x_we | output | 1 | Load X |
| x_new | output | 8 | New X |
| sp_out | output | 8 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, one cycle after `mem_re` |

## Verification
The assertions assume that reset comes first and that nothing but this block moves the pointer. They also assume the command handshake is the only way in. The strobe-exclusion and page checks assume no outside force on the memory port. The bench memory replies with exactly one cycle of latency. It raises `cmd_valid` only when the sequencer is idle and drops it right after acceptance. No command ever sits waiting against a low `cmd_ready`. The pointer is walked through all 256 values in both directions, so both wrap points are covered.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [3:0] {
    OP_PUSH_A = 4'd0,
    OP_PUSH_S = 4'd1,
    OP_PULL_A = 4'd2,
    OP_PULL_S = 4'd3,
    OP_CALL   = 4'd4,
    OP_RET    = 4'd5,
    OP_RETI   = 4'd6,
    OP_BRK    = 4'd7,
    OP_SP2X   = 4'd8,
    OP_X2SP   = 4'd9
  } stk_op_e;

  typedef enum logic [2:0] {WS_ACC, WS_STAT, WS_STATB, WS_RHI, WS_RLO} wsrc_e;
  typedef enum logic [1:0] {AS_STACK, AS_VLO, AS_VHI} asel_e;
  typedef enum logic [1:0] {CP_NONE, CP_DAT, CP_LO, CP_HI} cap_e;

  typedef struct packed {
    logic  wr;
    wsrc_e wsrc;
    logic  rd;
    asel_e asel;
    logic  sp_inc;
    logic  sp_dec;
    logic  sp_load;
    cap_e  cap;
    logic  last;
  } uop_t;

  localparam int FL_N = 7;
  localparam int FL_B = 4;
  localparam int FL_I = 2;
  localparam int FL_Z = 1;

  // Total cycles per command, counting the accept cycle as the first.
  function automatic logic [2:0] op_len(input logic [3:0] op);
    case (op)
      OP_PUSH_A, OP_PUSH_S:    return 3'd3;
      OP_PULL_A, OP_PULL_S:    return 3'd4;
      OP_CALL, OP_RET, OP_RETI: return 3'd6;
      OP_BRK:                  return 3'd7;
      default:                 return 3'd2;
    endcase
  endfunction

  function automatic logic [7:0] set_nz(input logic [7:0] st, input logic [7:0] v);
    logic [7:0] r;
    r       = st;
    r[FL_N] = v[7];
    r[FL_Z] = (v == 8'h00);
    return r;
  endfunction

endpackage

// File: rtl/stkseq_ptr.sv
module stkseq_ptr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] ptr,
  output logic [W-1:0] ptr_plus1
);
  localparam logic [W-1:0] ONE = W'(1);

  assign ptr_plus1 = ptr + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= INIT;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_plus1;
    else if (dec)  ptr <= ptr - ONE;
  end
endmodule

// File: rtl/stkseq_ucode.sv
module stkseq_ucode
  import stkseq_pkg::*;
(
  input  logic [3:0] op,
  input  logic [2:0] step,
  output uop_t       uop
);
  always_comb begin
    uop      = '0;
    uop.last = (step == op_len(op));
    case (op)
      OP_PUSH_A, OP_PUSH_S: begin
        if (step == 3'd2) begin
          uop.wr     = 1'b1;
          uop.wsrc   = (op == OP_PUSH_A) ? WS_ACC : WS_STAT;
          uop.sp_dec = 1'b1;
        end
      end
      OP_PULL_A, OP_PULL_S: begin
        if (step == 3'd2) begin
          uop.rd = 1'b1; uop.sp_inc = 1'b1;
        end
        if (step == 3'd3) uop.cap = CP_DAT;
      end
      OP_CALL: begin
        if (step == 3'd2 || step == 3'd3) begin
          uop.wr     = 1'b1;
          uop.wsrc   = (step == 3'd2) ? WS_RHI : WS_RLO;
          uop.sp_dec = 1'b1;
        end
      end
      OP_RET: begin
        if (step == 3'd2 || step == 3'd3) begin
          uop.rd = 1'b1; uop.sp_inc = 1'b1;
        end
        if (step == 3'd3) uop.cap = CP_LO;
        if (step == 3'd4) uop.cap = CP_HI;
      end
      OP_RETI: begin
        if (step >= 3'd2 && step <= 3'd4) begin
          uop.rd = 1'b1; uop.sp_inc = 1'b1;
        end
        if (step == 3'd3) uop.cap = CP_DAT;
        if (step == 3'd4) uop.cap = CP_LO;
        if (step == 3'd5) uop.cap = CP_HI;
      end
      OP_BRK: begin
        if (step >= 3'd2 && step <= 3'd4) begin
          uop.wr     = 1'b1;
          uop.sp_dec = 1'b1;
          uop.wsrc   = (step == 3'd2) ? WS_RHI : (step == 3'd3) ? WS_RLO : WS_STATB;
        end
        if (step == 3'd5) begin
          uop.rd = 1'b1; uop.asel = AS_VLO;
        end
        if (step == 3'd6) begin
          uop.rd = 1'b1; uop.asel = AS_VHI; uop.cap = CP_LO;
        end
      end
      OP_X2SP: if (step == 3'd2) uop.sp_load = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stkseq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_op,
  input  logic [15:0] cmd_pc,
  input  logic [15:0] cmd_operand,
  input  logic [7:0]  cmd_acc,
  input  logic [7:0]  cmd_status,
  input  logic [7:0]  cmd_x,
  output logic        done,
  output logic        pc_we,
  output logic [15:0] pc_new,
  output logic        sr_we,
  output logic [7:0]  sr_new,
  output logic        acc_we,
  output logic [7:0]  acc_new,
  output logic        x_we,
  output logic [7:0]  x_new,
  output logic [7:0]  sp_out,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);
  localparam int            DW      = 8;
  localparam int            AW      = 16;
  localparam logic [AW-1:0] VEC_HI  = VEC_ADDR + AW'(1);
  localparam logic [AW-1:0] RET_OFS = AW'(2);

  logic          busy;
  logic [2:0]    step;
  logic [3:0]    op_q;
  logic [AW-1:0] pc_q, opnd_q, ret_addr;
  logic [DW-1:0] acc_q, st_q, x_q, dat_q, lo_q, hi_q;
  logic [DW-1:0] sp, sp_p1;
  uop_t          uop;

  stkseq_ucode u_ucode (.op(op_q), .step(step), .uop(uop));

  stkseq_ptr #(.W(DW), .INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .inc(busy & uop.sp_inc), .dec(busy & uop.sp_dec), .load(busy & uop.sp_load),
    .load_val(x_q), .ptr(sp), .ptr_plus1(sp_p1)
  );

  assign cmd_ready = !busy;
  assign done      = busy & uop.last;
  assign mem_we    = busy & uop.wr;
  assign mem_re    = busy & uop.rd;
  assign sp_out    = sp;
  assign ret_addr  = pc_q + RET_OFS;

  // Command acceptance and step sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; step <= 3'd0; op_q <= 4'd0;
      pc_q <= '0; opnd_q <= '0; acc_q <= '0; st_q <= '0; x_q <= '0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy <= 1'b1; step <= 3'd2; op_q <= cmd_op;
        pc_q <= cmd_pc; opnd_q <= cmd_operand;
        acc_q <= cmd_acc; st_q <= cmd_status; x_q <= cmd_x;
      end
    end else if (uop.last) begin
      busy <= 1'b0;
    end else begin
      step <= step + 3'd1;
    end
  end

  // Read-data capture, one cycle after each read strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (busy) begin
      case (uop.cap)
        CP_DAT:  dat_q <= mem_rdata;
        CP_LO:   lo_q  <= mem_rdata;
        CP_HI:   hi_q  <= mem_rdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (uop.wr)                mem_addr = {STACK_PAGE, sp};
    else if (uop.asel == AS_VLO) mem_addr = VEC_ADDR;
    else if (uop.asel == AS_VHI) mem_addr = VEC_HI;
    else                       mem_addr = {STACK_PAGE, sp_p1};
    case (uop.wsrc)
      WS_ACC:   mem_wdata = acc_q;
      WS_STAT:  mem_wdata = st_q;
      WS_STATB: mem_wdata = st_q | (8'h01 << FL_B);
      WS_RHI:   mem_wdata = ret_addr[AW-1:DW];
      default:  mem_wdata = ret_addr[DW-1:0];
    endcase
  end

  // Result values, strobed only in the completing cycle
  always_comb begin
    pc_we = 1'b0; sr_we = 1'b0; acc_we = 1'b0; x_we = 1'b0;
    pc_new = '0; sr_new = st_q; acc_new = dat_q; x_new = sp;
    case (op_q)
      OP_PULL_A: begin acc_we = done; sr_we = done; sr_new = set_nz(st_q, dat_q); end
      OP_PULL_S: begin sr_we = done; sr_new = dat_q; end
      OP_CALL:   begin pc_we = done; pc_new = opnd_q; end
      OP_RET:    begin pc_we = done; pc_new = {hi_q, lo_q} + AW'(1); end
      OP_RETI:   begin pc_we = done; pc_new = {hi_q, lo_q}; sr_we = done; sr_new = dat_q; end
      OP_BRK:    begin
        pc_we = done; pc_new = {mem_rdata, lo_q};
        sr_we = done; sr_new = st_q | (8'h01 << FL_I);
      end
      OP_SP2X:   begin x_we = done; sr_we = done; sr_new = set_nz(st_q, sp); end
      default: ;
    endcase
  end
endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp_out
);
  a_r13_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r13_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);

  a_r3_write_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[7:0] == sp_out);

  a_r3_push_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == 8'($past(sp_out) - 8'd1));

  a_r4_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[15:8] == STACK_PAGE) |=> sp_out == 8'($past(sp_out) + 8'd1));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready);

  a_r2_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);
endmodule

bind stack_seq stkseq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .sp_out(sp_out)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
  localparam logic [15:0] VEC = 16'hFFFE;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready;
  logic [3:0]  cmd_op = 0;
  logic [15:0] cmd_pc = 0, cmd_operand = 0;
  logic [7:0]  cmd_acc = 0, cmd_status = 0, cmd_x = 0;
  logic        done, pc_we, sr_we, acc_we, x_we, mem_we, mem_re;
  logic [15:0] pc_new, mem_addr;
  logic [7:0]  sr_new, acc_new, x_new, sp_out, mem_wdata;
  logic [7:0]  mem_rdata = 0;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_operand(cmd_operand), .cmd_acc(cmd_acc),
    .cmd_status(cmd_status), .cmd_x(cmd_x), .done(done), .pc_we(pc_we), .pc_new(pc_new),
    .sr_we(sr_we), .sr_new(sr_new), .acc_we(acc_we), .acc_new(acc_new), .x_we(x_we),
    .x_new(x_new), .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // Bench memory: stack page plus the two vector bytes, one-cycle read latency.
  logic [7:0] ram [256];
  logic [7:0] vlo = 8'h34, vhi = 8'h12;
  int strobes = 0;
  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= (mem_addr == VEC) ? vlo :
                             (mem_addr == VEC + 16'd1) ? vhi : ram[mem_addr[7:0]];
    if (mem_we || mem_re) strobes <= strobes + 1;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic        g_pc_we, g_sr_we, g_acc_we, g_x_we, g_rdy_bad, g_rdy_after;
  logic [15:0] g_pc;
  logic [7:0]  g_sr, g_acc, g_x, g_sp;
  int          g_cyc, g_str;

  task automatic run(input logic [3:0] op, input logic [15:0] pc, input logic [15:0] opnd,
                     input logic [7:0] a, input logic [7:0] s, input logic [7:0] x);
    int s0;
    @(negedge clk);
    cmd_op = op; cmd_pc = pc; cmd_operand = opnd; cmd_acc = a; cmd_status = s; cmd_x = x;
    cmd_valid = 1'b1; s0 = strobes;
    @(posedge clk);
    g_cyc = 1; g_rdy_bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      g_cyc++;
      if (cmd_ready) g_rdy_bad = 1;
      if (done) begin
        g_pc_we = pc_we; g_pc = pc_new; g_sr_we = sr_we; g_sr = sr_new;
        g_acc_we = acc_we; g_acc = acc_new; g_x_we = x_we; g_x = x_new;
        break;
      end
    end
    @(negedge clk);
    g_rdy_after = cmd_ready; g_sp = sp_out; g_str = strobes - s0;
    chk("R2 ready low while busy", {31'd0, g_rdy_bad}, 32'd0);
    chk("R2 ready after done", {31'd0, g_rdy_after}, 32'd1);
  endtask

  function automatic logic [7:0] nz(input logic [7:0] s, input logic [7:0] v);
    logic [7:0] r;
    r = s; r[7] = v[7]; r[1] = (v == 8'h00);
    return r;
  endfunction

  logic [7:0] esp;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", {24'd0, sp_out}, 32'hFF);
    chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 idle strobes", {29'd0, done, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;
    esp = 8'hFF;

    // R3 push sweep over every pointer value, through the 00 -> FF wrap
    for (int i = 0; i < 256; i++) begin
      run(4'd0, 16'h0, 16'h0, 8'(i), 8'h65, 8'h0);
      chk("R3 pushed byte", {24'd0, ram[esp]}, i);
      chk("R3 pointer dec", {24'd0, g_sp}, {24'd0, 8'(esp - 8'd1)});
      chk("R2 push cycles", g_cyc, 3);
      chk("R5 push no strobe", {29'd0, g_sr_we, g_acc_we, g_pc_we}, 0);
      chk("R13 push accesses", g_str, 1);
      esp = esp - 8'd1;
    end
    // R4 pull sweep, LIFO order, through the FF -> 00 wrap
    for (int i = 255; i >= 0; i--) begin
      run(4'd2, 16'h0, 16'h0, 8'h0, 8'h65, 8'h0);
      esp = esp + 8'd1;
      chk("R4 pointer inc", {24'd0, g_sp}, {24'd0, esp});
      chk("R5 pulled acc", {23'd0, g_acc_we, g_acc}, {23'd0, 1'b1, 8'(i)});
      chk("R5 pulled flags", {23'd0, g_sr_we, g_sr}, {23'd0, 1'b1, nz(8'h65, 8'(i))});
      chk("R2 pull cycles", g_cyc, 4);
      chk("R13 pull accesses", g_str, 1);
    end

    // R6 status round trip
    run(4'd1, 16'h0, 16'h0, 8'h0, 8'hA5, 8'h0);
    chk("R5 status push raw", {24'd0, ram[esp]}, 32'hA5);
    run(4'd3, 16'h0, 16'h0, 8'h0, 8'h00, 8'h0);
    chk("R6 pulled status", {23'd0, g_sr_we, g_sr}, {23'd0, 1'b1, 8'hA5});

    // R7 / R8 call and return
    run(4'd4, 16'h1234, 16'hBEEF, 8'h0, 8'h0, 8'h0);
    chk("R7 high byte first", {24'd0, ram[esp]}, 32'h12);
    chk("R7 low byte second", {24'd0, ram[8'(esp - 8'd1)]}, 32'h36);
    chk("R7 target", {15'd0, g_pc_we, g_pc}, {15'd0, 1'b1, 16'hBEEF});
    chk("R7 cycles", g_cyc, 6);
    chk("R13 call accesses", g_str, 2);
    chk("R7 pointer", {24'd0, g_sp}, {24'd0, 8'(esp - 8'd2)});
    run(4'd5, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
    chk("R8 return plus one", {15'd0, g_pc_we, g_pc}, {15'd0, 1'b1, 16'h1237});
    chk("R8 cycles", g_cyc, 6);
    chk("R8 pointer", {24'd0, g_sp}, {24'd0, esp});
    run(4'd4, 16'hFFFE, 16'h0100, 8'h0, 8'h0, 8'h0);
    run(4'd5, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
    chk("R8 wrapped return", {16'd0, g_pc}, 32'h0001);
    run(4'd0, 16'h0, 16'h0, 8'hFF, 8'h0, 8'h0);
    run(4'd0, 16'h0, 16'h0, 8'hFF, 8'h0, 8'h0);
    run(4'd5, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
    chk("R8 return modulo", {16'd0, g_pc}, 32'h0000);

    // R9 return from interrupt
    run(4'd0, 16'h0, 16'h0, 8'h40, 8'h0, 8'h0);
    run(4'd0, 16'h0, 16'h0, 8'h10, 8'h0, 8'h0);
    run(4'd0, 16'h0, 16'h0, 8'hC3, 8'h0, 8'h0);
    run(4'd6, 16'h0, 16'h0, 8'h0, 8'h00, 8'h0);
    chk("R9 status", {23'd0, g_sr_we, g_sr}, {23'd0, 1'b1, 8'hC3});
    chk("R9 address no increment", {15'd0, g_pc_we, g_pc}, {15'd0, 1'b1, 16'h4010});
    chk("R9 cycles", g_cyc, 6);
    chk("R9 pointer", {24'd0, g_sp}, {24'd0, esp});

    // R10 break
    run(4'd7, 16'h2000, 16'h0, 8'h0, 8'h20, 8'h0);
    chk("R10 pushed high", {24'd0, ram[esp]}, 32'h20);
    chk("R10 pushed low", {24'd0, ram[8'(esp - 8'd1)]}, 32'h02);
    chk("R10 pushed status", {24'd0, ram[8'(esp - 8'd2)]}, 32'h30);
    chk("R10 vector", {15'd0, g_pc_we, g_pc}, {15'd0, 1'b1, 16'h1234});
    chk("R10 status out", {23'd0, g_sr_we, g_sr}, {23'd0, 1'b1, 8'h24});
    chk("R10 cycles", g_cyc, 7);
    chk("R13 break accesses", g_str, 5);
    chk("R10 pointer", {24'd0, g_sp}, {24'd0, 8'(esp - 8'd3)});

    // R12 / R11 transfers
    run(4'd9, 16'h0, 16'h0, 8'h0, 8'h00, 8'h00);
    chk("R12 pointer loaded", {24'd0, g_sp}, 32'h00);
    chk("R12 no status strobe", {31'd0, g_sr_we}, 0);
    chk("R12 cycles", g_cyc, 2);
    run(4'd8, 16'h0, 16'h0, 8'h0, 8'h80, 8'h0);
    chk("R11 x zero", {23'd0, g_x_we, g_x}, {23'd0, 1'b1, 8'h00});
    chk("R11 zero flag", {23'd0, g_sr_we, g_sr}, {23'd0, 1'b1, 8'h02});
    run(4'd0, 16'h0, 16'h0, 8'h5A, 8'h0, 8'h0);
    chk("R3 push at 0x0100", {24'd0, ram[8'h00]}, 32'h5A);
    chk("R3 wrap to FF", {24'd0, g_sp}, 32'hFF);
    run(4'd9, 16'h0, 16'h0, 8'h0, 8'h00, 8'h80);
    run(4'd8, 16'h0, 16'h0, 8'h0, 8'h02, 8'h0);
    chk("R11 negative", {15'd0, g_sr, g_x}, {15'd0, 8'h80, 8'h80});

    // R14 unused codes
    for (int c = 10; c < 16; c++) begin
      run(4'(c), 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
      chk("R14 cycles", g_cyc, 2);
      chk("R14 no access", g_str, 0);
      chk("R14 no strobe", {28'd0, g_pc_we, g_sr_we, g_acc_we, g_x_we}, 0);
      chk("R14 pointer kept", {24'd0, g_sp}, 32'h80);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule